// File: doc/BRIEF.md
# Address-Stability Auto-Sleep Controller

This block sits between a requester's address bus and a memory array. It watches the address. When the address has not changed for a programmable number of clock cycles, it puts the array to sleep. That number of cycles is the access latency plus a fixed safety margin. While asleep, the block drops the array enable, and its read-data output register keeps the last value it loaded.

Any change of address wakes the block and starts a fresh access. The new read data reaches the output only once the access latency has run out. The chip-enable, write-enable and output-enable strobes pass straight through to the array. They play no part in deciding when the block sleeps or wakes.

The access latency and the margin are both parameters, counted in clock cycles. Reset is asynchronous and active-low. Its release is synchronised to the clock inside the block.

Top module: `addr_idle_sleep`

## Requirements
- R1: While reset is held, `dout` is all zeros, `sleep` is 0 and `arr_en` is 1.
- R2: Take the clock edge that first registers a new address as edge 0. `sleep` rises at edge ACC_CYC+MARGIN_CYC, provided the address has stayed the same. It is still 0 after edge ACC_CYC+MARGIN_CYC-1.
- R3: Toggling `ce_n`, `we_n` or `oe_n` changes neither the time at which `sleep` rises nor its value while asleep.
- R4: A change of address while asleep brings `sleep` back to 0 at the next clock edge, and `arr_en` back to 1.
- R5: After an address change, `dout` takes the array read data at edge ACC_CYC and not earlier. The read data is taken for the new address, which is the value on `arr_addr`.
- R6: At every edge other than the load edge of R5, `dout` holds its value. This includes the whole sleep period, even when `arr_rdata` changes.
- R7: If the address changes again before ACC_CYC edges have passed, the access restarts. The data for the abandoned address never reaches `dout`.
- R8: `arr_ce_n`, `arr_we_n` and `arr_oe_n` follow `ce_n`, `we_n` and `oe_n` combinationally. `arr_en` is the inverse of `sleep`. `arr_addr` is the address as registered at the last clock edge.
- R9: As long as the address stays the same, `sleep` stays 1 for any length of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Address from the requester |
| ce_n | input | 1 | Chip enable, active low, passed through |
| we_n | input | 1 | Write enable, active low, passed through |
| oe_n | input | 1 | Output enable, active low, passed through |
| arr_rdata | input | DW | Read data returned by the array |
| arr_addr | output | AW | Registered address driven to the array |
| arr_en | output | 1 | Array enable, low while asleep |
| arr_ce_n | output | 1 | Copy of ce_n |
| arr_we_n | output | 1 | Copy of we_n |
| arr_oe_n | output | 1 | Copy of oe_n |
| dout | output | DW | Latched read data |
| sleep | output | 1 | Sleep indicator |

## Verification
The bench samples `dout` one edge before the load edge and again on the load edge. A design that samples the array early would show data too soon, and one that samples late would show the new data a cycle behind. It checks `sleep` on both sides of the terminal count, so an off-by-one in the stability counter fails either the early check or the late check. It changes the array contents while the block is asleep, which exposes a design that keeps reloading `dout`. It also aborts an access halfway through: a design that does not clear its counter on every mismatch would either latch the abandoned address's data or sleep too early.

// File: rtl/asp_pkg.sv
package asp_pkg;
  // Bits needed to hold the values 0..n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((1 << b) <= n) b++;
    return b;
  endfunction
endpackage

// File: rtl/asp_rst_sync.sv
module asp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/asp_addr_watch.sv
module asp_addr_watch #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] addr_q,
  output logic          addr_chg
);
  logic [AW-1:0] addr_d;

  assign addr_chg = (addr != addr_q);
  assign addr_d   = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/asp_stab_counter.sv
module asp_stab_counter #(
  parameter int unsigned ACC_CYC    = 4,
  parameter int unsigned MARGIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_chg,
  output logic load,
  output logic sleep
);
  import asp_pkg::*;

  localparam int unsigned TERM = ACC_CYC + MARGIN_CYC;
  localparam int unsigned CW   = cnt_bits(TERM);
  localparam logic [CW-1:0] TERM_V = CW'(TERM);
  localparam logic [CW-1:0] LOAD_V = CW'(ACC_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sleep_d;
  logic          cnt_en;

  // The counter saturates at the terminal count and stops there.
  assign cnt_en = addr_chg || (cnt_q != TERM_V);

  always_comb begin
    cnt_d = cnt_q;
    if (addr_chg)    cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  assign sleep_d = (cnt_d == TERM_V);
  assign load    = !addr_chg && (cnt_q == LOAD_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sleep <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      sleep <= sleep_d;
    end
  end

  AST_WAKE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> !sleep); // R4
  AST_SLEEP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !addr_chg) |=> sleep); // R9
  AST_LOAD_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !sleep); // R5
endmodule

// File: rtl/asp_data_latch.sv
module asp_data_latch #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] dout_d;

  assign dout_d = rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= dout_d;
  end
endmodule

// File: rtl/addr_idle_sleep.sv
module addr_idle_sleep #(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 16,
  parameter int unsigned ACC_CYC    = 4,
  parameter int unsigned MARGIN_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_rdata,
  output logic [AW-1:0] arr_addr,
  output logic          arr_en,
  output logic          arr_ce_n,
  output logic          arr_we_n,
  output logic          arr_oe_n,
  output logic [DW-1:0] dout,
  output logic          sleep
);
  logic rst_n_s;
  logic addr_chg;
  logic load;

  asp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  asp_addr_watch #(.AW(AW)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .addr     (addr),
    .addr_q   (arr_addr),
    .addr_chg (addr_chg)
  );

  asp_stab_counter #(.ACC_CYC(ACC_CYC), .MARGIN_CYC(MARGIN_CYC)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .addr_chg (addr_chg),
    .load     (load),
    .sleep    (sleep)
  );

  asp_data_latch #(.DW(DW)) u_latch (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (load),
    .rdata (arr_rdata),
    .dout  (dout)
  );

  assign arr_en   = !sleep;
  assign arr_ce_n = ce_n;
  assign arr_we_n = we_n;
  assign arr_oe_n = oe_n;

  AST_SLEEP_ON_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(sleep) |-> $stable(arr_addr)); // R2
  AST_HOLD_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sleep && $past(sleep)) |-> $stable(dout)); // R6
endmodule

// File: tb/sim_addr_idle_sleep.sv
module sim_addr_idle_sleep;
  localparam int unsigned AW = 16, DW = 16, ACC = 4, MAR = 3;
  localparam int unsigned TERM = ACC + MAR;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic ce_n, we_n, oe_n;
  logic [DW-1:0] arr_rdata, dout, salt;
  logic [AW-1:0] arr_addr;
  logic arr_en, arr_ce_n, arr_we_n, arr_oe_n, sleep;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_dout;

  always #5 clk = ~clk;

  // Array model: read data depends on the registered address and a salt.
  assign arr_rdata = arr_addr ^ salt;

  addr_idle_sleep #(.AW(AW), .DW(DW), .ACC_CYC(ACC), .MARGIN_CYC(MAR)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_en(arr_en),
    .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n), .arr_oe_n(arr_oe_n),
    .dout(dout), .sleep(sleep)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr = '0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; salt = 16'h5A3C;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 dout", dout, 0);
    chk("R1 sleep", sleep, 0);
    chk("R1 arr_en", arr_en, 1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_dout = '0;
  endtask

  // Issue a fresh address and follow it through load and sleep entry.
  task automatic t_access(input logic [AW-1:0] a);
    addr = a;
    repeat (ACC) @(posedge clk);
    #1;
    chk("R5 not yet loaded", dout, exp_dout);
    chk("R8 arr_addr", arr_addr, a);
    @(posedge clk); #1;
    exp_dout = a ^ salt;
    chk("R5 loaded", dout, exp_dout);
    repeat (TERM - ACC - 1) @(posedge clk);
    #1;
    chk("R2 awake before terminal", sleep, 0);
    @(posedge clk); #1;
    chk("R2 asleep at terminal", sleep, 1);
    chk("R8 arr_en low", arr_en, 0);
  endtask

  task automatic t_hold();
    salt = salt ^ 16'hFFFF;
    repeat (20) @(posedge clk);
    #1;
    chk("R6 dout held in sleep", dout, exp_dout);
    chk("R9 still asleep", sleep, 1);
  endtask

  task automatic t_wake(input logic [AW-1:0] a);
    addr = a;
    @(posedge clk); #1;
    chk("R4 wake", sleep, 0);
    chk("R4 arr_en", arr_en, 1);
    chk("R6 held while waking", dout, exp_dout);
    repeat (ACC - 1) @(posedge clk);
    #1;
    chk("R5 wake no early load", dout, exp_dout);
    @(posedge clk); #1;
    exp_dout = a ^ salt;
    chk("R5 wake load", dout, exp_dout);
    repeat (TERM - ACC) @(posedge clk);
    #1;
    chk("R2 asleep after wake", sleep, 1);
  endtask

  task automatic t_ctrl(input logic [AW-1:0] a);
    addr = a;
    for (int i = 0; i < TERM; i++) begin
      ce_n = i[0]; we_n = i[1]; oe_n = ~i[0];
      #1;
      chk("R8 ce pass", arr_ce_n, ce_n);
      chk("R8 we pass", arr_we_n, we_n);
      chk("R8 oe pass", arr_oe_n, oe_n);
      @(posedge clk); #1;
    end
    chk("R3 awake before terminal", sleep, 0);
    @(posedge clk); #1;
    chk("R3 asleep despite strobes", sleep, 1);
    exp_dout = a ^ salt;
    for (int i = 0; i < 6; i++) begin
      ce_n = ~ce_n; we_n = ~we_n; oe_n = ~oe_n;
      @(posedge clk); #1;
    end
    chk("R3 stays asleep", sleep, 1);
    chk("R6 dout after strobes", dout, exp_dout);
  endtask

  task automatic t_restart(input logic [AW-1:0] a1, input logic [AW-1:0] a2);
    addr = a1;
    repeat (ACC - 1) @(posedge clk);
    #1;
    addr = a2;
    repeat (ACC) @(posedge clk);
    #1;
    chk("R7 abandoned not loaded", dout, exp_dout);
    chk("R7 no sleep", sleep, 0);
    @(posedge clk); #1;
    exp_dout = a2 ^ salt;
    chk("R7 restarted load", dout, exp_dout);
    repeat (TERM - ACC) @(posedge clk);
    #1;
    chk("R7 sleep after restart", sleep, 1);
  endtask

  initial begin
    t_reset();
    t_access(16'h1234);
    t_hold();
    t_wake(16'hBEEF);
    t_ctrl(16'h0F0F);
    t_restart(16'h4444, 16'h7777);
    t_access(16'h0001);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule